// File: doc/BRIEF.md
# Field-Configurable Two-Level Logic Array

This block is a small programmable logic array. Both of its planes are set by configuration bits. Each input supplies two literals: its true value and its complement. Any product term may take any mix of those literals. Each output then ORs any chosen set of product terms, and an optional inversion stage follows the OR. The block can therefore produce a sum-of-products or its complement on every output. Product terms are shared freely among outputs.

The configuration sits in a shift register. It is loaded one bit per rising edge of `clk` while `cfg_en` is high. During a load the outputs are held at zero, so a half-written pattern never reaches them. Once `cfg_en` drops, the stored pattern stays fixed and evaluation is purely combinational from `in_vec` to `out_vec`. The defaults are 3 inputs, 4 product terms and 3 outputs, which gives a 39-bit configuration word.

Top module: `fpla_array`

## Requirements
- R1: A synchronous active-low reset clears every configuration bit. With `cfg_en` low after reset, `out_vec` is all zero for every input value.
- R2: While `cfg_en` is high, `out_vec` is all zero whatever the inputs and the stored pattern.
- R3: Each rising edge of `clk` with `cfg_en` high shifts `cfg_din` in, and the first bit shifted ends up as the most significant bit of the word. The bits are counted by their arrival index k, starting at 0, and bit k sits at word position CFG_W-1-k. The layout is as follows:
  - AND connections take k = t*2*N_IN + 2*i + p, where t is the term, i is the input, and p is 0 for the true literal and 1 for the complement.
  - OR connections follow them, at k = AND_W + o*N_TERM + t.
  - Inversion bits come last, at k = AND_W + OR_W + o.
- R4: While `cfg_en` is low, activity on `cfg_din` and clock edges leave the stored pattern, and so the input-to-output function, unchanged.
- R5: A product term is the AND of every literal whose connection bit is 1. A bit of 0 leaves that literal out.
- R6: A product term with no literal connected evaluates to 1.
- R7: Each output is the OR of the product terms whose OR bit is 1, and one term may feed several outputs. An output with no term connected evaluates to 0 before inversion.
- R8: When an output's inversion bit is 1, that output is the complement of its OR result.
- R9: With `cfg_en` low, `out_vec` follows a change of `in_vec` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Synchronous active-low reset of the configuration |
| cfg_en | input | 1 | High to shift in configuration; blanks the outputs |
| cfg_din | input | 1 | Serial configuration bit |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
The outputs are combinational, so a change of `in_vec` or of `cfg_en` is due at `out_vec` in the same cycle, before any clock edge. The bench drives every change just after a falling edge and samples 1 ns later. A new pattern is due only after exactly CFG_W rising edges with `cfg_en` high, followed by `cfg_en` going low. A reset takes effect at the first rising edge it covers. Each of these checks is made half a cycle after the edge that should have caused the change, never at an edge.

// File: rtl/pla_pkg.sv
// pla_pkg: shared helpers for the configurable logic array.
// Assumes configuration words are loaded MSB first, so the arrival index k
// of a bit maps to word position (cfg_w - 1 - k).
package pla_pkg;

    typedef enum logic {
        LIT_TRUE = 1'b0,
        LIT_COMP = 1'b1
    } lit_pol_e;

    // Arrival index of the AND-plane bit for term t, input i, literal polarity p.
    function automatic int and_idx(int t, int i, int p, int n_in);
        return t * 2 * n_in + 2 * i + p;
    endfunction

    // Arrival index of the OR-plane bit linking term t to output o.
    function automatic int or_idx(int o, int t, int n_term, int and_w);
        return and_w + o * n_term + t;
    endfunction

    // Arrival index of the inversion bit for output o.
    function automatic int pol_idx(int o, int and_w, int or_w);
        return and_w + or_w + o;
    endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
// pla_cfg_shift: serial configuration store.
// Shifts cfg_din in at the LSB when shift_en is high, so the first bit
// ends up at the MSB. Assumes rst_n is synchronous and active low.
module pla_cfg_shift #(
    parameter int CFG_W = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [CFG_W-1:0] cfg_q
);

    // Clear on reset, otherwise shift one bit per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (shift_en)
            cfg_q <= {cfg_q[CFG_W-2:0], din};
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> cfg_q == '0);

    // R3
    shift_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> cfg_q[0] == $past(din));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg_q));

endmodule

// File: rtl/pla_and_plane.sv
// pla_and_plane: programmable product terms.
// mask[t][2*i+p] = 1 connects literal (input i, true when p=0, complement
// when p=1) to term t. A term with no connection evaluates to 1.
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4
) (
    input  logic [N_IN-1:0]                  in_vec,
    input  logic [N_TERM-1:0][2*N_IN-1:0]    mask,
    output logic [N_TERM-1:0]                term
);

    localparam int LIT_W = 2 * N_IN;

    logic [LIT_W-1:0] lit;

    // Build the true/complement literal pair for each input.
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i + int'(pla_pkg::LIT_TRUE)] = in_vec[i];
        assign lit[2*i + int'(pla_pkg::LIT_COMP)] = ~in_vec[i];
    end

    // Each term ANDs its connected literals; unconnected ones count as 1.
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign term[t] = &(~mask[t] | lit);
    end

endmodule

// File: rtl/pla_or_plane.sv
// pla_or_plane: programmable sums with per-output inversion.
// sel[o][t] = 1 links term t to output o; an empty sum is 0 before the
// inversion stage, which XORs with inv[o].
module pla_or_plane #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 3
) (
    input  logic [N_TERM-1:0]              term,
    input  logic [N_OUT-1:0][N_TERM-1:0]   sel,
    input  logic [N_OUT-1:0]               inv,
    output logic [N_OUT-1:0]               sum_out
);

    // OR the selected terms, then apply the programmable polarity.
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign sum_out[o] = (|(term & sel[o])) ^ inv[o];
    end

endmodule

// File: rtl/fpla_array.sv
// fpla_array: field-configurable two-level logic array (top).
// Loads a CFG_W-bit pattern serially while cfg_en is high, blanking the
// outputs meanwhile; evaluation from in_vec to out_vec is combinational.
module fpla_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);

    localparam int AND_W = N_TERM * 2 * N_IN;
    localparam int OR_W  = N_OUT * N_TERM;
    localparam int CFG_W = AND_W + OR_W + N_OUT;

    logic [CFG_W-1:0]                cfg_q;
    logic [N_TERM-1:0][2*N_IN-1:0]   and_mask;
    logic [N_OUT-1:0][N_TERM-1:0]    or_sel;
    logic [N_OUT-1:0]                inv;
    logic [N_TERM-1:0]               term;
    logic [N_OUT-1:0]                sum_out;

    pla_cfg_shift #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .cfg_q    (cfg_q)
    );

    // Unpack the AND-plane connections from the configuration word.
    for (genvar t = 0; t < N_TERM; t++) begin : g_am
        for (genvar i = 0; i < N_IN; i++) begin : g_ai
            for (genvar p = 0; p < 2; p++) begin : g_ap
                assign and_mask[t][2*i+p] =
                    cfg_q[CFG_W-1-pla_pkg::and_idx(t, i, p, N_IN)];
            end
        end
    end

    // Unpack the OR-plane links and inversion bits.
    for (genvar o = 0; o < N_OUT; o++) begin : g_om
        for (genvar t = 0; t < N_TERM; t++) begin : g_ot
            assign or_sel[o][t] =
                cfg_q[CFG_W-1-pla_pkg::or_idx(o, t, N_TERM, AND_W)];
        end
        assign inv[o] = cfg_q[CFG_W-1-pla_pkg::pol_idx(o, AND_W, OR_W)];
    end

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec (in_vec),
        .mask   (and_mask),
        .term   (term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term    (term),
        .sel     (or_sel),
        .inv     (inv),
        .sum_out (sum_out)
    );

    // Blank the outputs while a pattern is being shifted in.
    assign out_vec = cfg_en ? '0 : sum_out;

    // R2
    blank_during_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> out_vec == '0);

endmodule

// File: tb/fpla_array_test.sv
`timescale 1ns/1ps
module fpla_array_test;

    localparam int N_IN   = 3;
    localparam int N_TERM = 4;
    localparam int N_OUT  = 3;
    localparam int AND_W  = N_TERM * 2 * N_IN;
    localparam int OR_W   = N_OUT * N_TERM;
    localparam int CFG_W  = AND_W + OR_W + N_OUT;

    localparam logic [CFG_W-1:0] PATS [6] = '{
        39'h40_0A00_1C05,
        39'h12_3456_789A,
        39'h7F_FFFF_FFFF,
        39'h25_9100_F0E2,
        39'h00_8421_5AA3,
        39'h6C_03F0_0C71
    };

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_en = 0;
    logic cfg_din = 0;
    logic [N_IN-1:0] in_vec = '0;
    logic [N_OUT-1:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fpla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    // Reference model built from the bit layout in R3, R5-R8.
    function automatic logic [N_OUT-1:0] model(logic [CFG_W-1:0] w, logic [N_IN-1:0] x);
        logic [N_OUT-1:0] r;
        for (int o = 0; o < N_OUT; o++) begin
            logic acc = 1'b0;
            for (int t = 0; t < N_TERM; t++) begin
                logic tv = 1'b1;
                for (int i = 0; i < N_IN; i++) begin
                    if (w[CFG_W-1-(t*2*N_IN+2*i)])   tv &= x[i];
                    if (w[CFG_W-1-(t*2*N_IN+2*i+1)]) tv &= ~x[i];
                end
                if (w[CFG_W-1-(AND_W+o*N_TERM+t)]) acc |= tv;
            end
            r[o] = acc ^ w[CFG_W-1-(AND_W+OR_W+o)];
        end
        return r;
    endfunction

    task automatic check(string req, logic [N_OUT-1:0] exp);
        checks++;
        if (out_vec !== exp) begin
            errors++;
            $display("FAIL %s: in=%b out=%b expected=%b", req, in_vec, out_vec, exp);
        end
    endtask

    // Shift a word in MSB first; checks blanking mid-load (R2).
    task automatic load(logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_en = 1;
        for (int k = 0; k < CFG_W; k++) begin
            cfg_din = w[CFG_W-1-k];
            if (k == CFG_W / 2) begin
                in_vec = 3'b101;
                #1 check("R2", '0);
            end
            @(negedge clk);
        end
        cfg_en = 0;
        cfg_din = 0;
    endtask

    // Apply every input value and compare against the model (R3,R5,R7,R8,R9).
    task automatic sweep(string req, logic [CFG_W-1:0] w);
        for (int v = 0; v < (1 << N_IN); v++) begin
            in_vec = v[N_IN-1:0];
            #1 check(req, model(w, in_vec));
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: out=%b expected=finish", out_vec);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [CFG_W-1:0] rw;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: after reset all outputs 0 for every input
        for (int v = 0; v < 8; v++) begin
            in_vec = v[2:0];
            #1 check("R1", '0);
        end

        // Table walk: R3/R5/R7/R8 via the model
        for (int n = 0; n < 6; n++) begin
            load(PATS[n]);
            sweep("R3", PATS[n]);
        end

        // Random pattern
        rw = {$urandom, $urandom};
        load(rw);
        sweep("R5", rw);

        // R4: idle clocks with cfg_din toggling change nothing
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
        end
        sweep("R4", rw);

        // R2: raising cfg_en blanks outputs at once
        @(negedge clk);
        in_vec = 3'b111;
        cfg_en = 1;
        #1 check("R2", '0);
        cfg_en = 0;

        // R8 + R6/R7: nothing connected, all inverted -> all ones
        load(39'h7);
        in_vec = 3'b010;
        #1 check("R8", 3'b111);

        // R6: empty term linked to output 0 -> output 0 is 1
        load(39'h1 << 14);
        in_vec = 3'b110;
        #1 check("R6", 3'b001);

        // R5/R7: term0 = in0 & ~in1 feeding output 1; R9 same-cycle follow
        load((39'h1 << 38) | (39'h1 << 35) | (39'h1 << 10));
        for (int v = 0; v < 8; v++) begin
            in_vec = v[2:0];
            #1 check("R9", {1'b0, in_vec[0] & ~in_vec[1], 1'b0});
        end

        // R1: reset clears a loaded pattern
        load(39'h7);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1 check("R1", '0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule